// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides whether a received Ethernet frame is kept, using only its 48-bit destination address. When the receive path has collected the address it pulses a strobe with the address alongside. One clock later the filter returns a valid pulse, an accept flag and a code that says which rule admitted the frame.

Four rules can admit a frame. Four programmable exact-match slots are checked first. The all-ones broadcast address has its own rule. A 64-bit hash table is indexed by six bits of the CRC-32 of the address, with separate enables for unicast and multicast frames. A promiscuous copy-all mode admits anything that no other rule took. A no-broadcast mode turns the broadcast address away. The hash index is computed inside the block. The configuration inputs are plain levels that a register file elsewhere drives.

Top module: `da_filter`

## Requirements
- R1: After reset, `res_valid` and `accept` are 0 and `match_kind` is 0 (reject).
- R2: `res_valid` is high exactly in the cycle after `da_valid` was sampled high. `accept` and `match_kind` are updated only on a strobe and otherwise hold their values.
- R3: Address byte k is `da[8k+7:8k]`, and byte 0 is the first byte on the wire. A frame is multicast when `da[0]` is 1. Slot n (0..3) holds the address `{slot_hi[16n+15:16n], slot_lo[32n+31:32n]}`. A non-broadcast address equal to slot n is accepted with `match_kind` = n+1. When several slots are equal, the lowest n wins.
- R4: The all-ones address with `cfg_no_bcast` clear is accepted with `match_kind` = 6, whatever the slots, hash and copy-all settings are.
- R5: The all-ones address with `cfg_no_bcast` set is rejected (`match_kind` 0) unless `cfg_copy_all` is set, in which case `match_kind` = 7. Slots and hash table have no effect on this address.
- R6: A multicast, non-broadcast address that matches no slot is accepted with `match_kind` = 5 when `cfg_mc_hash_en` is set and the table bit selected by its hash index is 1.
- R7: A unicast address that matches no slot is accepted with `match_kind` = 5 when `cfg_uc_hash_en` is set and its selected table bit is 1. The multicast enable has no effect on unicast frames, and the unicast enable has none on multicast frames.
- R8: The hash index is bits 31..26 of a CRC-32 register (polynomial 0x04C11DB7, preset to all ones, no final inversion), fed `da[0]` first through `da[47]`, with register bit 31 as index bit 5. The table bit is bit `idx` of `{hash_hi, hash_lo}`.
- R9: A non-broadcast address that no slot or hash rule admits is accepted with `match_kind` = 7 when `cfg_copy_all` is set, and is otherwise rejected with `match_kind` 0.
- R10: `accept` is 1 exactly when `match_kind` is not 0. Priority for non-broadcast addresses is slot, then hash, then copy-all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| da_valid | input | 1 | Destination address strobe |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| cfg_copy_all | input | 1 | Admit every frame no other rule took |
| cfg_no_bcast | input | 1 | Reject the all-ones address |
| cfg_mc_hash_en | input | 1 | Enable the hash rule for multicast frames |
| cfg_uc_hash_en | input | 1 | Enable the hash rule for unicast frames |
| hash_hi | input | 32 | Hash table bits 63..32 |
| hash_lo | input | 32 | Hash table bits 31..0 |
| slot_lo | input | 128 | Slot address bytes 0..3, 32 bits per slot |
| slot_hi | input | 64 | Slot address bytes 4..5, 16 bits per slot |
| res_valid | output | 1 | Result valid, one cycle after the strobe |
| accept | output | 1 | Frame accepted |
| match_kind | output | 3 | 0 reject, 1..4 slot, 5 hash, 6 broadcast, 7 copy-all |

## Verification
The hardest cases to reach from the ports are those where rules overlap. Examples are an address that sits in two slots and also hits a set hash bit, and a hash hit on one exact, known index. Uniformly random addresses almost never equal a slot. The stimulus therefore often takes its address from a random slot or from a neighbouring slot that holds the same value. It runs against hash tables that are dense, sparse or set at a single bit that the bench's own reflected-CRC model places. It also flips the multicast bit of slot-derived addresses, so that both hash enables are tested on the same table.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;
  localparam int ADDR_W   = 48;
  localparam int KIND_W   = 3;
  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef enum logic [KIND_W-1:0] {
    KIND_REJECT  = 3'd0,
    KIND_SLOT0   = 3'd1,
    KIND_SLOT1   = 3'd2,
    KIND_SLOT2   = 3'd3,
    KIND_SLOT3   = 3'd4,
    KIND_HASH    = 3'd5,
    KIND_BCAST   = 3'd6,
    KIND_COPYALL = 3'd7
  } match_kind_e;

  // MSB-first CRC register, address bits fed from bit 0 upward
  function automatic logic [5:0] crc_hash_index(input logic [ADDR_W-1:0] a);
    logic [31:0] c;
    logic fb;
    c = '1;
    for (int i = 0; i < ADDR_W; i++) begin
      fb = c[31] ^ a[i];
      c = {c[30:0], 1'b0};
      if (fb) c = c ^ CRC_POLY;
    end
    return c[31:26];
  endfunction
endpackage

// File: rtl/da_hash_lookup.sv
module da_hash_lookup
  import da_filter_pkg::*;
#(
  parameter int IDX_W = 6,
  localparam int TBL_N = 1 << IDX_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [TBL_N-1:0]  table_bits,
  output logic [IDX_W-1:0]  idx,
  output logic              bit_set
);
  always_comb begin
    idx     = IDX_W'(crc_hash_index(addr));
    bit_set = table_bits[idx];
  end
endmodule

// File: rtl/da_slot_match.sv
module da_slot_match
  import da_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  localparam int SEL_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NUM_SLOTS*32-1:0]  slot_lo,
  input  logic [NUM_SLOTS*16-1:0]  slot_hi,
  output logic [NUM_SLOTS-1:0]     hit_vec,
  output logic                     hit_any,
  output logic [SEL_W-1:0]         hit_sel
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_cmp
    assign hit_vec[g] = (addr == {slot_hi[16*g +: 16], slot_lo[32*g +: 32]});
  end

  always_comb begin
    hit_sel = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_sel = SEL_W'(i);
    end
  end

  assign hit_any = |hit_vec;
endmodule

// File: rtl/da_filter.sv
module da_filter
  import da_filter_pkg::*;
#(
  parameter int NUM_SLOTS = 4,
  parameter int IDX_W     = 6,
  localparam int TBL_N    = 1 << IDX_W,
  localparam int SEL_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    da_valid,
  input  logic [47:0]             da,
  input  logic                    cfg_copy_all,
  input  logic                    cfg_no_bcast,
  input  logic                    cfg_mc_hash_en,
  input  logic                    cfg_uc_hash_en,
  input  logic [31:0]             hash_hi,
  input  logic [31:0]             hash_lo,
  input  logic [NUM_SLOTS*32-1:0] slot_lo,
  input  logic [NUM_SLOTS*16-1:0] slot_hi,
  output logic                    res_valid,
  output logic                    accept,
  output logic [2:0]              match_kind
);
  // named internal events
  logic                 is_bcast, is_mcast;
  logic [NUM_SLOTS-1:0] slot_hit_vec;
  logic                 slot_hit;
  logic [SEL_W-1:0]     slot_sel;
  logic [IDX_W-1:0]     hash_idx;
  logic                 hash_bit;
  logic                 hash_ok;
  match_kind_e          kind_nxt;

  da_slot_match #(.NUM_SLOTS(NUM_SLOTS)) u_slots (
    .addr(da), .slot_lo(slot_lo), .slot_hi(slot_hi),
    .hit_vec(slot_hit_vec), .hit_any(slot_hit), .hit_sel(slot_sel)
  );

  da_hash_lookup #(.IDX_W(IDX_W)) u_hash (
    .addr(da), .table_bits(TBL_N'({hash_hi, hash_lo})),
    .idx(hash_idx), .bit_set(hash_bit)
  );

  assign is_bcast = &da;
  assign is_mcast = da[0];
  assign hash_ok  = hash_bit & (is_mcast ? cfg_mc_hash_en : cfg_uc_hash_en);

  always_comb begin
    if (is_bcast) begin
      if (!cfg_no_bcast)     kind_nxt = KIND_BCAST;
      else if (cfg_copy_all) kind_nxt = KIND_COPYALL;
      else                   kind_nxt = KIND_REJECT;
    end else if (slot_hit) begin
      kind_nxt = match_kind_e'(KIND_W'(slot_sel) + KIND_W'(1));
    end else if (hash_ok) begin
      kind_nxt = KIND_HASH;
    end else if (cfg_copy_all) begin
      kind_nxt = KIND_COPYALL;
    end else begin
      kind_nxt = KIND_REJECT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      accept     <= 1'b0;
      match_kind <= KIND_REJECT;
    end else begin
      res_valid <= da_valid;
      if (da_valid) begin
        accept     <= (kind_nxt != KIND_REJECT);
        match_kind <= kind_nxt;
      end
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    da_valid |=> res_valid); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> !res_valid); // R2
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !da_valid |=> ($stable(match_kind) && $stable(accept))); // R2
  AST_ACCEPT_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    accept == (match_kind != 3'd0)); // R10
  AST_BCAST_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da) && cfg_no_bcast && !cfg_copy_all) |=> !accept); // R5
  AST_BCAST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && (&da) && !cfg_no_bcast) |=> (match_kind == 3'd6)); // R4
  AST_COPYALL_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && cfg_copy_all) |=> accept); // R9
  AST_SLOT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !is_bcast && slot_hit) |=> (match_kind >= 3'd1 && match_kind <= 3'd4)); // R3
  AST_HASH_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (da_valid && !is_bcast && !slot_hit && !hash_bit && !cfg_copy_all) |=> !accept); // R6
endmodule

// File: tb/da_filter_tb_top.sv
module da_filter_tb_top;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic         rst_n;
  logic         da_valid;
  logic [47:0]  da;
  logic         cfg_copy_all, cfg_no_bcast, cfg_mc_hash_en, cfg_uc_hash_en;
  logic [31:0]  hash_hi, hash_lo;
  logic [127:0] slot_lo;
  logic [63:0]  slot_hi;
  logic         res_valid, accept;
  logic [2:0]   match_kind;

  int total = 0;
  int bad   = 0;

  da_filter dut_i (
    .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
    .cfg_copy_all(cfg_copy_all), .cfg_no_bcast(cfg_no_bcast),
    .cfg_mc_hash_en(cfg_mc_hash_en), .cfg_uc_hash_en(cfg_uc_hash_en),
    .hash_hi(hash_hi), .hash_lo(hash_lo), .slot_lo(slot_lo), .slot_hi(slot_hi),
    .res_valid(res_valid), .accept(accept), .match_kind(match_kind)
  );

  // reflected CRC, shifted right; index bits come from the low end reversed
  function automatic logic [5:0] ref_index(input logic [47:0] a);
    logic [31:0] r;
    r = 32'hFFFFFFFF;
    for (int i = 0; i < 48; i++) begin
      logic b;
      b = r[0] ^ a[i];
      r = r >> 1;
      if (b) r = r ^ 32'hEDB88320;
    end
    return {r[0], r[1], r[2], r[3], r[4], r[5]};
  endfunction

  function automatic logic [47:0] slot_addr(input int n);
    return {slot_hi[16*n +: 16], slot_lo[32*n +: 32]};
  endfunction

  function automatic logic [2:0] ref_kind(input logic [47:0] a);
    logic [63:0] tbl;
    tbl = {hash_hi, hash_lo};
    if (a == 48'hFFFF_FFFF_FFFF)
      return !cfg_no_bcast ? 3'd6 : (cfg_copy_all ? 3'd7 : 3'd0);
    for (int n = 0; n < 4; n++)
      if (a == slot_addr(n)) return 3'(n + 1);
    if (tbl[ref_index(a)] && (a[0] ? cfg_mc_hash_en : cfg_uc_hash_en)) return 3'd5;
    if (cfg_copy_all) return 3'd7;
    return 3'd0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one strobe; result sampled on the falling edge after the capturing edge
  task automatic apply(input logic [47:0] a, input string req);
    logic [2:0] k;
    @(negedge clk);
    da = a; da_valid = 1'b1;
    k = ref_kind(a);
    @(negedge clk);
    da_valid = 1'b0;
    check({req, " kind"}, 32'(match_kind), 32'(k));
    check({req, " accept"}, 32'(accept), 32'(k != 3'd0)); // R10
    check({req, " valid"}, 32'(res_valid), 32'd1);
  endtask

  task automatic idle_hold(input string req);
    logic [2:0] k0;
    logic a0;
    k0 = match_kind; a0 = accept;
    @(negedge clk);
    da = ~da;
    @(negedge clk);
    check({req, " valid low"}, 32'(res_valid), 32'd0);
    check({req, " kind held"}, 32'(match_kind), 32'(k0));
    check({req, " accept held"}, 32'(accept), 32'(a0));
  endtask

  task automatic rand_cfg();
    int d;
    cfg_copy_all   = ($urandom % 4) == 0;
    cfg_no_bcast   = $urandom % 2;
    cfg_mc_hash_en = $urandom % 2;
    cfg_uc_hash_en = $urandom % 2;
    d = $urandom % 3;
    hash_hi = (d == 0) ? $urandom : ((d == 1) ? ($urandom & $urandom & $urandom) : '1);
    hash_lo = (d == 0) ? $urandom : ((d == 1) ? ($urandom & $urandom & $urandom) : '1);
    for (int n = 0; n < 4; n++) begin
      slot_lo[32*n +: 32] = $urandom;
      slot_hi[16*n +: 16] = 16'($urandom);
    end
    if (($urandom % 4) == 0) begin
      slot_lo[63:32] = slot_lo[127:96];
      slot_hi[31:16] = slot_hi[63:48];
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    logic [5:0] ix;
    logic [47:0] a;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; da_valid = 1'b0; da = '0;
    cfg_copy_all = 0; cfg_no_bcast = 0; cfg_mc_hash_en = 0; cfg_uc_hash_en = 0;
    hash_hi = '0; hash_lo = '0; slot_lo = '0; slot_hi = '0;
    repeat (3) @(negedge clk);
    check("R1 valid", 32'(res_valid), 0);
    check("R1 accept", 32'(accept), 0);
    check("R1 kind", 32'(match_kind), 0);
    rst_n = 1'b1;

    // R3: slots with distinct values, then duplicate in slots 1 and 3
    for (int n = 0; n < 4; n++) begin
      slot_lo[32*n +: 32] = 32'h1111_0000 + 32'(n) * 32'h10;
      slot_hi[16*n +: 16] = 16'hA000 + 16'(n);
    end
    for (int n = 0; n < 4; n++) apply(slot_addr(n), "R3 slot");
    slot_lo[127:96] = slot_lo[63:32]; slot_hi[63:48] = slot_hi[31:16];
    apply(slot_addr(3), "R3 lowest slot wins");
    check("R3 dup kind", 32'(match_kind), 32'd2);
    idle_hold("R2");

    // R4 / R5 broadcast
    slot_lo[31:0] = '1; slot_hi[15:0] = '1; hash_hi = '1; hash_lo = '1;
    cfg_mc_hash_en = 1; cfg_copy_all = 1;
    apply(48'hFFFF_FFFF_FFFF, "R4 bcast");
    check("R4 code", 32'(match_kind), 6);
    cfg_no_bcast = 1; cfg_copy_all = 0;
    apply(48'hFFFF_FFFF_FFFF, "R5 bcast blocked");
    check("R5 code", 32'(match_kind), 0);
    cfg_copy_all = 1;
    apply(48'hFFFF_FFFF_FFFF, "R5 bcast copyall");
    check("R5 copyall code", 32'(match_kind), 7);
    slot_lo[31:0] = 32'h1111_0000; slot_hi[15:0] = 16'hA000;
    cfg_copy_all = 0; cfg_no_bcast = 0;

    // R8/R6/R7: single table bit at bench-derived index
    a = 48'h0000_2345_6701;
    ix = ref_index(a);
    {hash_hi, hash_lo} = 64'd1 << ix;
    cfg_mc_hash_en = 1; cfg_uc_hash_en = 0;
    apply(a, "R6 R8 mcast single bit");
    check("R8 hit code", 32'(match_kind), 5);
    {hash_hi, hash_lo} = ~(64'd1 << ix);
    apply(a, "R8 other bits only");
    check("R8 miss code", 32'(match_kind), 0);
    a = 48'h0000_2345_6700;
    ix = ref_index(a);
    {hash_hi, hash_lo} = 64'd1 << ix;
    apply(a, "R7 mcast enable ignored for unicast");
    cfg_uc_hash_en = 1; cfg_mc_hash_en = 0;
    apply(a, "R7 ucast hit");
    check("R7 code", 32'(match_kind), 5);

    // R9/R10 copy-all and priority
    cfg_copy_all = 1;
    apply(48'h0000_0000_0002 ^ slot_addr(0), "R9 copyall miss");
    apply(slot_addr(2), "R10 slot over copyall");
    apply(a, "R10 hash over copyall");
    cfg_copy_all = 0;
    apply(48'h0000_0000_0002 ^ slot_addr(0), "R9 reject");

    // random mix
    for (int t = 0; t < 3000; t++) begin
      int s;
      if ((t % 20) == 0) rand_cfg();
      s = $urandom % 8;
      if (s < 2)       a = slot_addr($urandom % 4);
      else if (s == 2) a = slot_addr($urandom % 4) ^ 48'h1;
      else if (s == 3) a = 48'hFFFF_FFFF_FFFF;
      else             a = {16'($urandom), 32'($urandom)};
      apply(a, "R3-mix random");
      if ((t % 97) == 0) idle_hold("R2 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule